// File: doc/BRIEF.md
# Tap-Selectable Ring Clock Divider

This block divides a system clock by a ratio from 1 to 16 without a counter. A single token circulates through a 16-stage shift ring. A 4-bit tap address selects which stage closes the loop. Each time the token reaches the selected stage, the block raises a one-cycle enable pulse and sends the token back to stage 0. The ring period, and so the division ratio, is therefore the tap address plus one.

A second output toggles on every pulse. This gives a square wave at half the pulse rate with an exact 50% duty cycle. With a 20 MHz clock and tap address 4, the pulse runs at 4 MHz, which suits a serial interface clock enable. The square wave in that case runs at 2 MHz.

A new tap address is picked up only when the token wraps, so every period is either the old length or the new one. Reset is synchronous and active high.

Top module: `ring_clock_divider`

## Requirements
- R1: The ring length is 8*A3 + 4*A2 + 2*A1 + A0 + 1, where A3..A0 are bits 3..0 of `tapSel`. `divPulse` is high for exactly one cycle in every run of that many cycles, on the last cycle of each run, and exactly one token is ever in the ring.
- R2: While `rst` is high at a clock edge, the token is placed in stage 0 and `sqOut` is cleared to 0. After reset is released, the first `divPulse` comes in cycle L-1, where L is the length and cycle 0 is the first cycle after the last reset edge.
- R3: With `tapSel` = 0 (length 1), `divPulse` is high on every cycle.
- R4: With `tapSel` = 4'b0100, the pulse period is 5 cycles, so a 20 MHz clock yields a 4 MHz enable.
- R5: `sqOut` toggles at the clock edge that ends each `divPulse` cycle and is otherwise stable. It therefore has a period of 2L cycles and is high for L of them, which is divide-by-10 for `tapSel` = 4.
- R6: The block samples `tapSel` only at reset and at the edge that ends a pulse cycle. A change at any other time leaves the current period at its old length, and the new length applies from the next period.
- R7: With `tapSel` = 4'b1111, the period is 16 cycles, the longest the ring allows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tapSel | input | 4 | Tap address; ring length is tapSel + 1 |
| divPulse | output | 1 | One-cycle enable at the end of each ring period |
| sqOut | output | 1 | Square wave at half the pulse rate, 50% duty |

## Verification
The bench targets length 1, where a design that shifts the token away from stage 0 would skip pulses instead of pulsing every cycle. It also targets the longest tap, where an off-by-one would drop the token off the end of the ring or produce a 15-cycle period. Tap changes are made both mid-period and just after a wrap, in both directions. A design that applied `tapSel` immediately would produce a truncated period, or would strand the token past a shorter tap so that no further pulse ever came. The square wave is followed across each of these cases, because an error in its toggle would show as a lost or doubled edge and a duty cycle other than 50%.

// File: rtl/ring_div_pkg.sv
package ring_div_pkg;

  // Strobes from the control side to the ring datapath.
  typedef struct packed {
    logic wrap;   // token sits on the active tap: restart at stage 0
    logic shift;  // token moves one stage forward
  } divStrobe_t;

endpackage

// File: rtl/ring_div_datapath.sv
module ring_div_datapath
  import ring_div_pkg::*;
#(
  parameter int STAGES = 16,
  localparam int TAP_W = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  divStrobe_t       strb,
  input  logic [TAP_W-1:0] curTap,
  output logic             tapBit
);

  logic [STAGES-1:0] ring;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) ring[0] <= 1'b1;
          else     ring[0] <= strb.wrap;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) ring[i] <= 1'b0;
          else     ring[i] <= strb.shift & ring[i-1];
        end
      end
    end
  endgenerate

  assign tapBit = ring[curTap];

  // R1
  token_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(ring));

  // R2
  reset_token_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ring == STAGES'(1)));

endmodule

// File: rtl/ring_div_control.sv
module ring_div_control
  import ring_div_pkg::*;
#(
  parameter int STAGES = 16,
  localparam int TAP_W = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAP_W-1:0] tapSel,
  input  logic             tapBit,
  output divStrobe_t       strb,
  output logic [TAP_W-1:0] curTap,
  output logic             divPulse,
  output logic             sqOut
);

  always_comb begin
    strb.wrap  = tapBit;
    strb.shift = ~tapBit;
  end

  // The active tap is only replaced when the token wraps.
  always_ff @(posedge clk) begin
    if (rst || strb.wrap) curTap <= tapSel;
  end

  always_ff @(posedge clk) begin
    if (rst)            sqOut <= 1'b0;
    else if (strb.wrap) sqOut <= ~sqOut;
  end

  assign divPulse = tapBit;

  // R6
  tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.wrap |=> $stable(curTap));

  // R5
  sq_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    strb.wrap |=> (sqOut != $past(sqOut)));

  // R5
  sq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.wrap |=> $stable(sqOut));

  // R3
  unit_len_chk: assert property (@(posedge clk) disable iff (rst)
    (curTap == '0) |-> tapBit);

endmodule

// File: rtl/ring_clock_divider.sv
module ring_clock_divider
  import ring_div_pkg::*;
#(
  parameter int STAGES = 16,
  localparam int TAP_W = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAP_W-1:0] tapSel,
  output logic             divPulse,
  output logic             sqOut
);

  divStrobe_t       strb;
  logic [TAP_W-1:0] curTap;
  logic             tapBit;

  ring_div_control #(.STAGES(STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tapSel   (tapSel),
    .tapBit   (tapBit),
    .strb     (strb),
    .curTap   (curTap),
    .divPulse (divPulse),
    .sqOut    (sqOut)
  );

  ring_div_datapath #(.STAGES(STAGES)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .curTap (curTap),
    .tapBit (tapBit)
  );

endmodule

// File: tb/sim_ring_clock_divider.sv
module sim_ring_clock_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tapSel = 4'd0;
  logic       divPulse;
  logic       sqOut;

  int checks = 0;
  int errors = 0;

  // Requirement-based expectation: position within period, current length.
  int   pos;
  int   len;
  logic expSq;

  always #2 clk = ~clk;

  ring_clock_divider u0 (
    .clk(clk), .rst(rst), .tapSel(tapSel),
    .divPulse(divPulse), .sqOut(sqOut)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reset with a given tap; checks the state seen while reset is held (R2).
  task automatic doReset(input logic [3:0] tap);
    @(negedge clk);
    rst = 1'b1;
    tapSel = tap;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(sqOut == 1'b0, "R2", "sqOut in reset", sqOut, 0);
    check(divPulse == (tap == 4'd0), "R2", "divPulse in reset",
          divPulse, (tap == 4'd0));
    rst = 1'b0;
    pos = 0;
    len = int'(tap) + 1;
    expSq = 1'b0;
  endtask

  // Run n cycles from the current negedge; optionally change tapSel once
  // after cycle changeAt has been checked.
  task automatic runCycles(input int n, input string tag,
                           input int changeAt, input logic [3:0] newTap);
    for (int k = 0; k < n; k++) begin
      logic expPulse;
      if (k > 0) @(negedge clk);
      expPulse = (pos == len - 1);
      check(divPulse == expPulse, tag, $sformatf("divPulse cyc %0d", k),
            divPulse, expPulse);
      check(sqOut == expSq, tag, $sformatf("sqOut cyc %0d", k), sqOut, expSq);
      if (k == changeAt) tapSel = newTap;
      if (expPulse) begin
        pos = 0;
        len = int'(tapSel) + 1;
        expSq = ~expSq;
      end else begin
        pos++;
      end
    end
  endtask

  // Count pulses and sqOut high cycles over whole periods.
  task automatic measure(input logic [3:0] tap, input string tag);
    int pulses = 0;
    int highs = 0;
    int l = int'(tap) + 1;
    doReset(tap);
    for (int k = 0; k < 4 * l; k++) begin
      if (k > 0) @(negedge clk);
      pulses += int'(divPulse);
      highs += int'(sqOut);
    end
    check(pulses == 4, tag, $sformatf("pulses in 4 periods tap %0d", tap),
          pulses, 4);
    check(highs == 2 * l, tag, $sformatf("sq high cycles tap %0d", tap),
          highs, 2 * l);
  endtask

  task automatic testReset();
    doReset(4'd4);
    runCycles(6, "R2", -1, 4'd4);
  endtask

  task automatic testUnit();
    doReset(4'd0);
    runCycles(12, "R3", -1, 4'd0);
  endtask

  task automatic testFive();
    doReset(4'b0100);
    runCycles(40, "R4", -1, 4'b0100);
    measure(4'b0100, "R5");
  endtask

  task automatic testLongest();
    doReset(4'b1111);
    runCycles(50, "R7", -1, 4'b1111);
  endtask

  task automatic testAllTaps();
    for (int t = 0; t < 16; t++) begin
      doReset(4'(t));
      runCycles(3 * (t + 1), "R1", -1, 4'(t));
    end
  endtask

  task automatic testChange();
    // Shorten mid-period: 5 -> 2
    doReset(4'd4);
    runCycles(20, "R6", 1, 4'd1);
    // Lengthen right after reset: 2 -> 7
    doReset(4'd1);
    runCycles(24, "R6", 0, 4'd6);
    // Shrink below the token position: 16 -> 1, changed at cycle 10
    doReset(4'd15);
    runCycles(30, "R6", 10, 4'd0);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testUnit();
    testFive();
    testLongest();
    testAllTaps();
    testChange();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule